// File: doc/BRIEF.md
# Hart Status Word with Supervisor Alias

This block holds the single privileged status word of a 32-bit hart and presents it through two register views. The machine view sees and writes the whole word. The supervisor view is a masked alias of the same storage: reads return only the supervisor-visible fields, and writes merge into the word before going through the machine write rules. Each write updates only the fields that are legal to write. Fields that cannot be written keep their old value. The summary-dirty bit is never stored from write data; it is recomputed from the state fields.

An input selects between an older and a newer privilege-spec behaviour. This input changes both the writable set and the supervisor-visible set. In older-spec mode, a legacy translation-mode field is writable only with a supported encoding. When a write changes a field that affects address translation, the block raises a one-cycle pulse so that the translation cache can be invalidated.

Field positions used throughout: UIE 0, SIE 1, MIE 3, UPIE 4, SPIE 5, MPIE 7, SPP 8, MPP 12:11, FS 14:13, XS 16:15, MPRV 17, SUM 18, MXR 19, TVM 20, TW 21, TSR 22, legacy VM 28:24, SD 31.

Top module: `hart_status_reg`

## Requirements
- R1: After synchronous reset the machine view reads 0x0000_1800 (only MPP = 2'b11) and the translation-flush output is 0.
- R2: With spec_new = 1, a machine-view write changes exactly SIE, SPIE, MIE, MPIE, SPP, MPP, FS, MPRV, SUM, MXR, TVM, TW and TSR (mask 0x007E_79AA). Every other bit except SD keeps its value, so writing all ones from reset reads back 0x807E_79AA.
- R3: With spec_new = 0, TVM, TW and TSR are not writable. The 5-bit VM field at 28:24 is written only when the written code is 0 (bare) or 8 (paged). Any other code leaves VM unchanged.
- R4: After every write, SD (bit 31) is 1 exactly when FS = 2'b11 or XS = 2'b11, and 0 otherwise, whatever was written to bit 31.
- R5: xlat_flush is high for the one cycle after a write whose result changes MXR, MPP, MPRV or SUM, or changes VM when spec_new = 0. A write that changes none of these leaves it low.
- R6: The supervisor view reads the word ANDed with 0x800D_E133 when spec_new = 1 (UIE, SIE, UPIE, SPIE, SPP, FS, XS, SUM, MXR, SD). When spec_new = 0 it reads the word ANDed with 0x8005_E133 (MXR dropped).
- R7: A supervisor-view write (wr_sview = 1) first replaces only the supervisor-visible bits of the current word with write data. It then applies the machine-view legalization of R2 to R4, so machine-only fields such as MIE and MPP keep their value.
- R8: While wr_en = 0 the word does not change and xlat_flush stays 0, whatever wr_data and wr_sview carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_sview | input | 1 | 1 = write through the supervisor view, 0 = machine view |
| spec_new | input | 1 | 1 = newer privilege-spec rules, 0 = older rules |
| wr_data | input | 32 | Write data |
| mview_rdata | output | 32 | Machine view of the status word |
| sview_rdata | output | 32 | Supervisor view of the status word |
| xlat_flush | output | 1 | One-cycle translation-flush pulse following a qualifying write |

## Verification
The bench builds the block with its default parameters: a 32-bit word and supported legacy translation codes 0 and 8. These defaults let it write a valid code (8), an invalid one (16, and all ones) and a return to bare. In both spec modes it drives full-ones and zero words through each view. The expected words are worked out from the field masks. It covers SD being forced on and off, the MXR difference between the supervisor masks, and writes that change only interrupt enables, which must not flush.

// File: rtl/hsr_pkg.sv
// Package: field positions and fixed masks of the hart status word.
// Assumes a 32-bit word; all masks are derived from the positions below.
package hsr_pkg;
    localparam int XLEN      = 32;
    localparam int VM_W      = 5;

    localparam int P_UIE     = 0;
    localparam int P_SIE     = 1;
    localparam int P_MIE     = 3;
    localparam int P_UPIE    = 4;
    localparam int P_SPIE    = 5;
    localparam int P_MPIE    = 7;
    localparam int P_SPP     = 8;
    localparam int P_MPP_LO  = 11;
    localparam int P_FS_LO   = 13;
    localparam int P_XS_LO   = 15;
    localparam int P_MPRV    = 17;
    localparam int P_SUM     = 18;
    localparam int P_MXR     = 19;
    localparam int P_TVM     = 20;
    localparam int P_TW      = 21;
    localparam int P_TSR     = 22;
    localparam int P_VM_LO   = 24;
    localparam int P_SD      = XLEN - 1;

    typedef logic [XLEN-1:0] word_t;

    localparam word_t ONE    = word_t'(1);
    localparam word_t MPP_M  = word_t'(3) << P_MPP_LO;
    localparam word_t FS_M   = word_t'(3) << P_FS_LO;
    localparam word_t XS_M   = word_t'(3) << P_XS_LO;
    localparam word_t VM_M   = word_t'((1 << VM_W) - 1) << P_VM_LO;
    localparam word_t SD_M   = ONE << P_SD;

    // Writable in both spec modes.
    localparam word_t WR_COMMON = (ONE << P_SIE) | (ONE << P_SPIE) |
        (ONE << P_MIE) | (ONE << P_MPIE) | (ONE << P_SPP) | FS_M |
        (ONE << P_MPRV) | (ONE << P_SUM) | MPP_M | (ONE << P_MXR);
    // Extra writable fields in the newer mode.
    localparam word_t WR_NEW_EXTRA = (ONE << P_TVM) | (ONE << P_TSR) |
        (ONE << P_TW);

    // Supervisor-visible fields, older mode; newer mode adds MXR.
    localparam word_t SV_OLD = (ONE << P_SIE) | (ONE << P_SPIE) |
        (ONE << P_UIE) | (ONE << P_UPIE) | (ONE << P_SPP) | FS_M | XS_M |
        (ONE << P_SUM) | SD_M;
    localparam word_t SV_NEW = SV_OLD | (ONE << P_MXR);

    // Fields whose change invalidates translation in either mode.
    localparam word_t XLAT_M = (ONE << P_MXR) | MPP_M | (ONE << P_MPRV) |
        (ONE << P_SUM);

    localparam word_t RESET_WORD = MPP_M;
endpackage

// File: rtl/hsr_sview.sv
// Module: supervisor read view. Returns the status word restricted to the
// supervisor-visible fields; the field set depends on the spec mode.
// Assumes: purely combinational, no state.
module hsr_sview
    import hsr_pkg::*;
(
    input  word_t cur,
    input  logic  spec_new,
    output word_t smask,
    output word_t rdata
);
    // Pick the supervisor mask for the current mode and apply it.
    always_comb begin
        smask = spec_new ? SV_NEW : SV_OLD;
        rdata = cur & smask;
    end
endmodule

// File: rtl/hsr_legalize.sv
// Module: write legalization. Forms the next status word from the current
// word and write data: optional supervisor merge, writable-mask merge,
// conditional legacy VM update, then SD recomputation.
// Assumes: the caller only registers nxt when a write strobe is present.
module hsr_legalize
    import hsr_pkg::*;
#(
    parameter logic [VM_W-1:0] VM_CODE_BARE  = 5'd0,
    parameter logic [VM_W-1:0] VM_CODE_PAGED = 5'd8
)(
    input  word_t cur,
    input  word_t wdata,
    input  logic  sview,
    input  logic  spec_new,
    input  word_t smask,
    output word_t nxt
);
    word_t            merged;
    word_t            wmask;
    word_t            raw;
    logic [VM_W-1:0]  vm_code;
    logic             vm_ok;
    logic             dirty;

    // Supervisor writes replace only supervisor-visible bits first.
    always_comb begin
        merged = sview ? ((cur & ~smask) | (wdata & smask)) : wdata;
    end

    // Decide whether the written legacy VM code is supported.
    always_comb begin
        vm_code = merged[P_VM_LO +: VM_W];
        vm_ok   = (vm_code == VM_CODE_BARE) || (vm_code == VM_CODE_PAGED);
    end

    // Build the mode-dependent writable mask.
    always_comb begin
        if (spec_new) begin
            wmask = WR_COMMON | WR_NEW_EXTRA;
        end else begin
            wmask = WR_COMMON | (vm_ok ? VM_M : '0);
        end
    end

    // Merge under the mask, then derive SD from FS and XS.
    always_comb begin
        raw   = (cur & ~wmask) | (merged & wmask);
        dirty = ((raw & FS_M) == FS_M) || ((raw & XS_M) == XS_M);
        nxt   = (raw & ~SD_M) | (dirty ? SD_M : '0);
    end
endmodule

// File: rtl/hsr_flush_detect.sv
// Module: detects a change of translation-related fields between the current
// and the legalized next word. VM is included only in older-spec mode.
// Assumes: combinational; qualification by the write strobe is external.
module hsr_flush_detect
    import hsr_pkg::*;
(
    input  word_t cur,
    input  word_t nxt,
    input  logic  spec_new,
    output logic  changed
);
    word_t watch;

    // Compare watched fields of the old and new word.
    always_comb begin
        watch   = spec_new ? XLAT_M : (XLAT_M | VM_M);
        changed = ((cur ^ nxt) & watch) != '0;
    end
endmodule

// File: rtl/hart_status_reg.sv
// Module: hart status word with machine and supervisor views. Stores the
// word, applies legalized writes on wr_en, and registers a one-cycle
// translation-flush pulse. Assumes synchronous active-low reset.
module hart_status_reg
    import hsr_pkg::*;
#(
    parameter logic [VM_W-1:0] VM_CODE_BARE  = 5'd0,
    parameter logic [VM_W-1:0] VM_CODE_PAGED = 5'd8
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sview,
    input  logic            spec_new,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] mview_rdata,
    output logic [XLEN-1:0] sview_rdata,
    output logic            xlat_flush
);
    word_t status_q;
    word_t status_d;
    word_t smask;
    logic  xlat_chg;

    hsr_sview u_sview (
        .cur      (status_q),
        .spec_new (spec_new),
        .smask    (smask),
        .rdata    (sview_rdata)
    );

    hsr_legalize #(
        .VM_CODE_BARE  (VM_CODE_BARE),
        .VM_CODE_PAGED (VM_CODE_PAGED)
    ) u_legal (
        .cur      (status_q),
        .wdata    (wr_data),
        .sview    (wr_sview),
        .spec_new (spec_new),
        .smask    (smask),
        .nxt      (status_d)
    );

    hsr_flush_detect u_flush (
        .cur      (status_q),
        .nxt      (status_d),
        .spec_new (spec_new),
        .changed  (xlat_chg)
    );

    // Status word storage: reset value, else legalized write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RESET_WORD;
        end else if (wr_en) begin
            status_q <= status_d;
        end
    end

    // Flush pulse: high one cycle after a write that changed watched fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlat_flush <= 1'b0;
        end else begin
            xlat_flush <= wr_en & xlat_chg;
        end
    end

    assign mview_rdata = status_q;

    // R1: first cycle out of reset holds the reset word
    a_r1_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status_q == RESET_WORD && !xlat_flush));

    // R4: stored SD always agrees with FS/XS
    a_r4_sd_derived: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[P_SD] == (status_q[P_FS_LO +: 2] == 2'b11 ||
                           status_q[P_XS_LO +: 2] == 2'b11));

    // R8: no strobe, no change and no flush
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) |-> ($stable(status_q) && !xlat_flush));

    // R3: older mode never touches TVM/TW/TSR
    a_r3_old_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && !$past(spec_new) |->
        status_q[P_TSR:P_TVM] == $past(status_q[P_TSR:P_TVM]));

    // R5: a flush pulse only follows a real change of a watched field
    a_r5_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && xlat_flush |->
        ((status_q ^ $past(status_q)) &
         (XLAT_M | ($past(spec_new) ? '0 : VM_M))) != '0);

    // R6: supervisor view never exposes machine-only fields
    a_r6_sview_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sview_rdata & ~SV_NEW) == '0);
endmodule

// File: tb/tb_hart_status_reg.sv
// Directed bench for hart_status_reg: one task per scenario.
module tb_hart_status_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        wr_sview;
    logic        spec_new;
    logic [31:0] wr_data;
    logic [31:0] mview_rdata;
    logic [31:0] sview_rdata;
    logic        xlat_flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    hart_status_reg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sview    (wr_sview),
        .spec_new    (spec_new),
        .wr_data     (wr_data),
        .mview_rdata (mview_rdata),
        .sview_rdata (sview_rdata),
        .xlat_flush  (xlat_flush)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // One write; returns at the following falling edge, when the new word
    // and the flush pulse are both visible.
    task automatic wr(input logic sv, input logic nw, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sview = sv; spec_new = nw; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'h0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_sview = 1'b0; spec_new = 1'b1; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset mview", mview_rdata, 32'h0000_1800);
        check("R1", "reset flush", {31'b0, xlat_flush}, 32'h0);
        check("R6", "reset sview", sview_rdata, 32'h0);
    endtask

    task automatic t_new_all_ones();
        wr(1'b0, 1'b1, 32'hFFFF_FFFF);
        check("R2", "new ones", mview_rdata, 32'h807E_79AA);
        check("R4", "SD set by FS", {31'b0, mview_rdata[31]}, 32'h1);
        check("R5", "flush after xlat change", {31'b0, xlat_flush}, 32'h1);
        @(negedge clk);
        check("R5", "flush one cycle", {31'b0, xlat_flush}, 32'h0);
    endtask

    task automatic t_sview_read();
        spec_new = 1'b1; #1;
        check("R6", "sview new", sview_rdata, 32'h800C_6122);
        spec_new = 1'b0; #1;
        check("R6", "sview old", sview_rdata, 32'h8004_6122);
        spec_new = 1'b1;
    endtask

    task automatic t_sd_clear();
        wr(1'b0, 1'b1, 32'h0000_0000);
        check("R4", "SD cleared", mview_rdata, 32'h0000_0000);
        check("R5", "flush on clear", {31'b0, xlat_flush}, 32'h1);
    endtask

    task automatic t_old_mask();
        wr(1'b0, 1'b0, 32'hFFFF_FFFF);
        check("R3", "old ones, bad VM", mview_rdata, 32'h800E_79AA);
    endtask

    task automatic t_old_vm();
        wr(1'b0, 1'b0, 32'h0800_0000);
        check("R3", "VM paged accepted", mview_rdata, 32'h0800_0000);
        check("R5", "flush on VM/xlat", {31'b0, xlat_flush}, 32'h1);
        wr(1'b0, 1'b0, 32'h0800_0008);
        check("R5", "MIE only", mview_rdata, 32'h0800_0008);
        check("R5", "no flush MIE only", {31'b0, xlat_flush}, 32'h0);
        wr(1'b0, 1'b0, 32'h1000_0008);
        check("R3", "VM code 16 rejected", mview_rdata, 32'h0800_0008);
        check("R5", "no flush rejected VM", {31'b0, xlat_flush}, 32'h0);
        wr(1'b0, 1'b0, 32'h0000_0008);
        check("R3", "VM bare accepted", mview_rdata, 32'h0000_0008);
        check("R5", "flush on VM only", {31'b0, xlat_flush}, 32'h1);
    endtask

    task automatic t_flush_new();
        wr(1'b0, 1'b1, 32'h0000_1808);
        check("R5", "MPP write", mview_rdata, 32'h0000_1808);
        check("R5", "flush on MPP", {31'b0, xlat_flush}, 32'h1);
        wr(1'b0, 1'b1, 32'h0000_1800);
        check("R5", "no flush MIE clear", {31'b0, xlat_flush}, 32'h0);
        wr(1'b0, 1'b1, 32'h0000_0008);
        check("R2", "back to MIE", mview_rdata, 32'h0000_0008);
    endtask

    task automatic t_sview_write();
        wr(1'b1, 1'b1, 32'hFFFF_FFFF);
        check("R7", "sview ones", mview_rdata, 32'h800C_612A);
        check("R5", "flush sview SUM/MXR", {31'b0, xlat_flush}, 32'h1);
        wr(1'b1, 1'b1, 32'h0000_0000);
        check("R7", "sview zero keeps MIE", mview_rdata, 32'h0000_0008);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        wr_en = 1'b0; wr_sview = 1'b0; spec_new = 1'b1; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R8", "idle word", mview_rdata, 32'h0000_0008);
        check("R8", "idle flush", {31'b0, xlat_flush}, 32'h0);
        wr_data = '0;
    endtask

    initial begin
        t_reset();
        t_new_all_ones();
        t_sview_read();
        t_sd_clear();
        t_old_mask();
        t_old_vm();
        t_flush_new();
        t_sview_write();
        t_no_strobe();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule